// File: doc/BRIEF.md
# Patrol Scrub Address Tracker

This block produces the row/column addresses for DRAM patrol scrubbing and keeps one pointer register that serves three purposes. It records the address of the most recent scrub handed downstream. It logs the failing address reported by a memory test. It takes a start point written by software. Once software sets the enable and pulses start-scrub, the block offers addresses on a valid/ready stream. Each accepted address is followed by the next one, which advances the column by a fixed stride and carries into the row.

The first address offered after start is the one currently held, with no step applied first. When the row counter wraps back to zero, the block emits a one-cycle pass-complete pulse. Software writes take effect only while the enable is low. A write made while scrubbing is enabled is thrown away and raises a sticky flag. The next accepted write clears that flag.

Stream rules: `issue_valid` is high only while `scrub_en` is high and scrubbing has been started. A transfer takes place on any clock edge where `issue_valid` and `issue_ready` are both high. While valid waits for ready, the payload does not change, with two exceptions: a memory-test capture or a new start pulse may replace it. Dropping `scrub_en` withdraws valid at once.

Top module: `scrub_addr_tracker`

## Requirements
- R1: After reset the pointer reads back zero, and `issue_valid`, `pass_done` and `wr_dropped` are all low.
- R2: `issue_valid` is never high while `scrub_en` is low. After `scrub_en` falls, no address is offered again until a start pulse arrives while `scrub_en` is high.
- R3: The first address offered after an accepted start pulse equals the held pointer value, unchanged.
- R4: Each transfer (valid and ready both high) stores the transferred row/column in the pointer. It can be read back on `reg_rdata` after that edge.
- R5: After a transfer, the next address offered is column + COL_STRIDE modulo 2^COL_W. The row increments by one when that column sum overflows.
- R6: When the row overflows as well, it returns to zero. `pass_done` is high for exactly one cycle, the cycle after the transfer of that wrapped address.
- R7: `mt_err` loads {`mt_row`, `mt_col`} into the pointer on the next edge and wins over a transfer in the same cycle. Stepping then continues from the captured address.
- R8: A `reg_wr` while `scrub_en` is low loads the pointer: row from `reg_wdata[ROW_W+COL_W-1:COL_W]`, column from `reg_wdata[COL_W-1:0]`. It also clears `wr_dropped`.
- R9: A `reg_wr` while `scrub_en` is high leaves the pointer unchanged and sets `wr_dropped`, which stays set until an accepted write.
- R10: While `issue_valid` is high and `issue_ready` is low, the offered row/column stay stable unless `mt_err` or `start_pulse` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Patrol scrubbing enabled |
| start_pulse | input | 1 | Begin issuing at the held address |
| issue_valid | output | 1 | Scrub address offered |
| issue_ready | input | 1 | Downstream accepts the offered address |
| issue_row | output | ROW_W | Offered row |
| issue_col | output | COL_W | Offered column |
| pass_done | output | 1 | One-cycle pulse after a full sweep |
| mt_err | input | 1 | Memory-test error strobe |
| mt_row | input | ROW_W | Failing row |
| mt_col | input | COL_W | Failing column |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | ROW_W+COL_W | Write data: row high, column low |
| reg_rdata | output | ROW_W+COL_W | Pointer: row high, column low |
| wr_dropped | output | 1 | Sticky flag: a write was ignored |

## Verification
The bench builds the tracker with a 3-bit row, a 4-bit column and a column stride of 4. That gives four columns per row and eight rows, so a complete sweep is 32 transfers. With this setup a column carry into the row and a row wrap with its pass pulse are both reached within a few cycles after a software write to row 7, column 8. The small fields also make it simple to line up a memory-test capture with a transfer in the same cycle.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  // Source selected for the pointer register, highest priority first in decode.
  typedef enum logic [1:0] {
    LD_HOLD  = 2'd0,
    LD_MTEST = 2'd1,
    LD_SW    = 2'd2,
    LD_ISSUE = 2'd3
  } ld_sel_e;
endpackage

// File: rtl/scrub_step.sv
module scrub_step #(
  parameter int ROW_W      = 16,
  parameter int COL_W      = 14,
  parameter int COL_STRIDE = 8
) (
  input  logic [ROW_W-1:0] cur_row,
  input  logic [COL_W-1:0] cur_col,
  output logic [ROW_W-1:0] nxt_row,
  output logic [COL_W-1:0] nxt_col,
  output logic             col_wrap,
  output logic             row_wrap
);
  localparam logic [COL_W:0] STRIDE_EXT = (COL_W+1)'(COL_STRIDE);

  logic [COL_W:0] col_sum;
  logic [ROW_W:0] row_sum;

  always_comb begin
    col_sum  = {1'b0, cur_col} + STRIDE_EXT;
    col_wrap = col_sum[COL_W];
    nxt_col  = col_sum[COL_W-1:0];
    row_sum  = {1'b0, cur_row} + (ROW_W+1)'(col_wrap);
    row_wrap = row_sum[ROW_W];
    nxt_row  = row_sum[ROW_W-1:0];
  end
endmodule

// File: rtl/scrub_ptr_reg.sv
module scrub_ptr_reg
  import scrub_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int COL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ld_sel_e          sel,
  input  logic [ROW_W-1:0] mt_row,
  input  logic [COL_W-1:0] mt_col,
  input  logic [ROW_W-1:0] sw_row,
  input  logic [COL_W-1:0] sw_col,
  input  logic [ROW_W-1:0] is_row,
  input  logic [COL_W-1:0] is_col,
  output logic [ROW_W-1:0] held_row,
  output logic [COL_W-1:0] held_col
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_row <= '0;
      held_col <= '0;
    end else begin
      unique case (sel)
        LD_MTEST: begin held_row <= mt_row; held_col <= mt_col; end
        LD_SW:    begin held_row <= sw_row; held_col <= sw_col; end
        LD_ISSUE: begin held_row <= is_row; held_col <= is_col; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scrub_en,
  input  logic    start_pulse,
  input  logic    issue_ready,
  input  logic    reg_wr,
  input  logic    mt_err,
  input  logic    row_wrap,
  output logic    issue_valid,
  output logic    use_held,
  output ld_sel_e ld_sel,
  output logic    pass_done,
  output logic    wr_dropped
);
  logic active;
  logic first;
  logic xfer;
  logic sw_ok;
  logic sw_bad;

  always_comb begin
    issue_valid = active & scrub_en;
    xfer        = issue_valid & issue_ready;
    sw_ok       = reg_wr & ~scrub_en;
    sw_bad      = reg_wr & scrub_en;
    use_held    = first;
    if (mt_err)     ld_sel = LD_MTEST;
    else if (sw_ok) ld_sel = LD_SW;
    else if (xfer)  ld_sel = LD_ISSUE;
    else            ld_sel = LD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      first      <= 1'b1;
      pass_done  <= 1'b0;
      wr_dropped <= 1'b0;
    end else begin
      if (!scrub_en)        active <= 1'b0;
      else if (start_pulse) active <= 1'b1;

      if (start_pulse && scrub_en) first <= 1'b1;
      else if (sw_ok)              first <= 1'b1;
      else if (xfer)               first <= 1'b0;

      pass_done <= xfer & ~first & row_wrap;

      if (sw_bad)     wr_dropped <= 1'b1;
      else if (sw_ok) wr_dropped <= 1'b0;
    end
  end
endmodule

// File: rtl/scrub_addr_tracker.sv
module scrub_addr_tracker
  import scrub_pkg::*;
#(
  parameter int ROW_W      = 16,
  parameter int COL_W      = 14,
  parameter int COL_STRIDE = 8,
  localparam int ADDR_W    = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  input  logic              start_pulse,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [ROW_W-1:0]  issue_row,
  output logic [COL_W-1:0]  issue_col,
  output logic              pass_done,
  input  logic              mt_err,
  input  logic [ROW_W-1:0]  mt_row,
  input  logic [COL_W-1:0]  mt_col,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              wr_dropped
);
  logic [ROW_W-1:0] held_row, nxt_row;
  logic [COL_W-1:0] held_col, nxt_col;
  logic             col_wrap, row_wrap, use_held;
  ld_sel_e          ld_sel;

  scrub_step #(.ROW_W(ROW_W), .COL_W(COL_W), .COL_STRIDE(COL_STRIDE)) u_step (
    .cur_row (held_row), .cur_col (held_col),
    .nxt_row (nxt_row),  .nxt_col (nxt_col),
    .col_wrap(col_wrap), .row_wrap(row_wrap)
  );

  scrub_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .start_pulse(start_pulse),
    .issue_ready(issue_ready), .reg_wr(reg_wr), .mt_err(mt_err),
    .row_wrap(row_wrap), .issue_valid(issue_valid), .use_held(use_held),
    .ld_sel(ld_sel), .pass_done(pass_done), .wr_dropped(wr_dropped)
  );

  always_comb begin
    issue_row = use_held ? held_row : nxt_row;
    issue_col = use_held ? held_col : nxt_col;
    reg_rdata = {held_row, held_col};
  end

  scrub_ptr_reg #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sel(ld_sel),
    .mt_row(mt_row), .mt_col(mt_col),
    .sw_row(reg_wdata[ADDR_W-1:COL_W]), .sw_col(reg_wdata[COL_W-1:0]),
    .is_row(issue_row), .is_col(issue_col),
    .held_row(held_row), .held_col(held_col)
  );
endmodule

// File: rtl/scrub_tracker_chk.sv
module scrub_tracker_chk #(
  parameter int ROW_W = 16,
  parameter int COL_W = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scrub_en,
  input logic                   start_pulse,
  input logic                   issue_valid,
  input logic                   issue_ready,
  input logic [ROW_W-1:0]       issue_row,
  input logic [COL_W-1:0]       issue_col,
  input logic                   pass_done,
  input logic                   mt_err,
  input logic [ROW_W-1:0]       mt_row,
  input logic [COL_W-1:0]       mt_col,
  input logic                   reg_wr,
  input logic [ROW_W+COL_W-1:0] reg_rdata,
  input logic                   wr_dropped
);
  assert_valid_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scrub_en |-> !issue_valid);

  assert_start_at_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && scrub_en && !mt_err && !(issue_valid && issue_ready))
    |=> (!scrub_en || (issue_valid && {issue_row, issue_col} == $past(reg_rdata))));

  assert_record_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !mt_err)
    |=> reg_rdata == $past({issue_row, issue_col}));

  assert_pass_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> $past(issue_valid && issue_ready));

  assert_mtest_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mt_err |=> reg_rdata == $past({mt_row, mt_col}));

  assert_drop_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && scrub_en && !mt_err) |=> (wr_dropped && $stable(reg_rdata)));

  assert_hold_payload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready && !mt_err && !start_pulse)
    |=> (!issue_valid || ($stable(issue_row) && $stable(issue_col))));
endmodule

bind scrub_addr_tracker scrub_tracker_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .start_pulse(start_pulse),
  .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_row(issue_row),
  .issue_col(issue_col), .pass_done(pass_done), .mt_err(mt_err), .mt_row(mt_row),
  .mt_col(mt_col), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .wr_dropped(wr_dropped)
);

// File: tb/test_scrub_addr_tracker.sv
module test_scrub_addr_tracker;
  localparam int ROW_W = 3;
  localparam int COL_W = 4;
  localparam int AW    = ROW_W + COL_W;

  logic clk = 1'b0;
  logic rst_n, scrub_en, start_pulse, issue_ready, mt_err, reg_wr;
  logic [ROW_W-1:0] mt_row;
  logic [COL_W-1:0] mt_col;
  logic [AW-1:0]    reg_wdata, reg_rdata;
  logic             issue_valid, pass_done, wr_dropped;
  logic [ROW_W-1:0] issue_row;
  logic [COL_W-1:0] issue_col;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  scrub_addr_tracker #(.ROW_W(ROW_W), .COL_W(COL_W), .COL_STRIDE(4)) i_scrub_addr_tracker (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .start_pulse(start_pulse),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_row(issue_row),
    .issue_col(issue_col), .pass_done(pass_done), .mt_err(mt_err), .mt_row(mt_row),
    .mt_col(mt_col), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_dropped(wr_dropped)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int addr(input int r, input int c);
    return r * (1 << COL_W) + c;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; scrub_en = 1'b0; start_pulse = 1'b0; issue_ready = 1'b0;
    mt_err = 1'b0; reg_wr = 1'b0; mt_row = '0; mt_col = '0; reg_wdata = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1", "rdata", int'(reg_rdata), 0);
    chk("R1", "valid", int'(issue_valid), 0);
    chk("R1", "dropped", int'(wr_dropped), 0);
    chk("R1", "pass", int'(pass_done), 0);
  endtask

  task automatic t_sw_write(input int r, input int c);
    scrub_en = 1'b0; reg_wr = 1'b1; reg_wdata = AW'(addr(r, c));
    tick();
    reg_wr = 1'b0;
    chk("R8", "rdata after write", int'(reg_rdata), addr(r, c));
    chk("R8", "dropped cleared", int'(wr_dropped), 0);
  endtask

  task automatic t_start_and_step();
    scrub_en = 1'b1; start_pulse = 1'b1;
    tick();
    start_pulse = 1'b0;
    chk("R3", "valid", int'(issue_valid), 1);
    chk("R3", "first addr", addr(issue_row, issue_col), addr(5, 8));
    tick(); tick();
    chk("R10", "held payload", addr(issue_row, issue_col), addr(5, 8));
    issue_ready = 1'b1;
    tick();
    chk("R4", "recorded", int'(reg_rdata), addr(5, 8));
    chk("R5", "stride step", addr(issue_row, issue_col), addr(5, 12));
    tick();
    issue_ready = 1'b0;
    chk("R4", "recorded 2", int'(reg_rdata), addr(5, 12));
    chk("R5", "column carry", addr(issue_row, issue_col), addr(6, 0));
  endtask

  task automatic t_drop_write();
    reg_wr = 1'b1; reg_wdata = AW'(addr(1, 1));
    tick();
    reg_wr = 1'b0;
    chk("R9", "dropped set", int'(wr_dropped), 1);
    chk("R9", "pointer kept", int'(reg_rdata), addr(5, 12));
    tick();
    chk("R9", "dropped sticky", int'(wr_dropped), 1);
  endtask

  task automatic t_mtest_priority();
    mt_err = 1'b1; mt_row = 3'd2; mt_col = 4'd4; issue_ready = 1'b1;
    tick();
    mt_err = 1'b0; issue_ready = 1'b0;
    chk("R7", "capture wins", int'(reg_rdata), addr(2, 4));
    chk("R7", "step from capture", addr(issue_row, issue_col), addr(2, 8));
  endtask

  task automatic t_disable();
    scrub_en = 1'b0;
    #1;
    chk("R2", "valid drops", int'(issue_valid), 0);
    tick();
    scrub_en = 1'b1;
    tick();
    chk("R2", "no restart without start", int'(issue_valid), 0);
  endtask

  task automatic t_wrap();
    t_sw_write(7, 8);
    scrub_en = 1'b1; start_pulse = 1'b1;
    tick();
    start_pulse = 1'b0;
    chk("R3", "restart addr", addr(issue_row, issue_col), addr(7, 8));
    issue_ready = 1'b1;
    tick();
    chk("R6", "no early pass", int'(pass_done), 0);
    tick();
    chk("R6", "wrapped addr", addr(issue_row, issue_col), addr(0, 0));
    chk("R6", "no pass before xfer", int'(pass_done), 0);
    tick();
    issue_ready = 1'b0;
    chk("R6", "pass pulse", int'(pass_done), 1);
    chk("R4", "wrapped recorded", int'(reg_rdata), addr(0, 0));
    tick();
    chk("R6", "pass one cycle", int'(pass_done), 0);
  endtask

  initial begin
    t_reset();
    t_sw_write(5, 8);
    t_start_and_step();
    t_drop_write();
    t_mtest_priority();
    t_disable();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule